// File: doc/BRIEF.md
# Pin Change Notification Controller

This block watches a group of already-synchronized input pins and raises a single interrupt request when an enabled pin changes state. Software configures it through a control register, two per-pin enable registers and a per-pin flag register. The port that owns the pins signals each software read of its pin-state register with a one-cycle strobe.

There are two detection modes. In mismatch mode, every enabled pin is compared each clock against a reference captured at the last pin-register read. That read also clears the pending flags. In edge mode, rising and falling transitions are detected against the previous clock's sample. Each direction has its own enable per pin. Flags are cleared by writing ones to them. Detection can be switched off entirely. It can also be frozen while the system is idle.

Top module: `pin_change_notifier`

## Requirements
- R1: The control readback holds the enable bit at bit 15, stop-in-idle at bit 13 and edge mode at bit 11. Every other bit reads 0, and the register is 0 after reset.
- R2: While the enable bit is 0, no flag bit becomes set, whatever the pins do.
- R3: In mismatch mode (bit 11 = 0), a pin enabled in the A enable register whose sample differs from the reference sets its flag. The flag appears at the second rising clock edge after the pin changes, and it stays set until cleared. Pins not enabled in A never set a flag.
- R4: The interrupt output is high exactly while at least one flag bit is set.
- R5: A pin-read strobe in mismatch mode captures the current sample as the new reference and clears all flags. The pin read data equals the sampled pin values.
- R6: In edge mode (bit 11 = 1), enable register A arms rising-edge detection per pin and enable register B arms falling-edge detection per pin. A detected edge sets that pin's flag with the same two-edge latency as R3. An edge in a direction that is not armed sets nothing.
- R7: In edge mode, writing a 1 to a flag bit clears it. Flag bits written with 0 are kept.
- R8: While stop-in-idle is 1 and the idle input is high, no flag becomes set.
- R9: Pins are sampled on every clock, so an edge that lasts a single clock cycle is still flagged.
- R10: An edge that occurs while detection is off or halted is not flagged once detection resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | W | Synchronized pin levels |
| idle_in | input | 1 | System idle indication |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data |
| ctl_q | output | 16 | Control register readback |
| ena_we | input | 1 | Write strobe for enable A (mismatch / rising) |
| enb_we | input | 1 | Write strobe for enable B (falling) |
| flag_clr_we | input | 1 | Write-one-to-clear strobe for the flags (edge mode) |
| cfg_wdata | input | W | Per-pin write data for the enable and flag strobes |
| pin_rd | input | 1 | Strobe marking a software read of the pin register |
| pin_rdata | output | W | Sampled pin values |
| flags_q | output | W | Per-pin change flags |
| irq | output | 1 | Interrupt request |

## Verification
In mismatch mode, the pins are driven first onto enabled bits and then onto a disabled bit. A change back to the old level is also applied, to separate a sticky flag from a live comparison. A pin read is followed by a change away from the new value, which confirms that the reference really moved. In edge mode, each pin sees transitions in both directions with only one direction armed, which separates the rising enable from the falling enable. A single-cycle pulse shows that sampling happens every clock. Pin activity while the block is off or idle-halted, followed by re-enabling, shows that events are neither produced during the halt nor replayed after it.

// File: rtl/pin_change_notifier.sv
module pin_change_notifier #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_in,
  input  logic         idle_in,
  input  logic         ctl_we,
  input  logic [15:0]  ctl_wdata,
  output logic [15:0]  ctl_q,
  input  logic         ena_we,
  input  logic         enb_we,
  input  logic         flag_clr_we,
  input  logic [W-1:0] cfg_wdata,
  input  logic         pin_rd,
  output logic [W-1:0] pin_rdata,
  output logic [W-1:0] flags_q,
  output logic         irq
);
  localparam int ON_BIT   = 15;
  localparam int IDLE_BIT = 13;
  localparam int EDGE_BIT = 11;

  logic on_q, sidl_q, edge_q;
  logic [W-1:0] ena_q, enb_q, samp_q, prev_q, ref_q, hit, flags_d;
  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      sidl_q <= 1'b0;
      edge_q <= 1'b0;
      ena_q  <= '0;
      enb_q  <= '0;
    end else begin
      if (ctl_we) begin
        on_q   <= ctl_wdata[ON_BIT];
        sidl_q <= ctl_wdata[IDLE_BIT];
        edge_q <= ctl_wdata[EDGE_BIT];
      end
      if (ena_we) ena_q <= cfg_wdata;
      if (enb_we) enb_q <= cfg_wdata;
    end
  end

  always_comb begin
    ctl_q = '0;
    ctl_q[ON_BIT]   = on_q;
    ctl_q[IDLE_BIT] = sidl_q;
    ctl_q[EDGE_BIT] = edge_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      prev_q <= '0;
      ref_q  <= '0;
    end else begin
      samp_q <= pins_in;
      prev_q <= samp_q;
      if (pin_rd) ref_q <= samp_q;
    end
  end

  assign active = on_q && !(sidl_q && idle_in);
  assign hit = edge_q ? ((ena_q & samp_q & ~prev_q) | (enb_q & ~samp_q & prev_q))
                      : (ena_q & (samp_q ^ ref_q));

  always_comb begin
    flags_d = flags_q;
    if (edge_q) begin
      if (flag_clr_we) flags_d = flags_d & ~cfg_wdata;
    end else if (pin_rd) begin
      flags_d = '0;
    end
    if (active && !(pin_rd && !edge_q)) flags_d = flags_d | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign pin_rdata = samp_q;
  assign irq = |flags_q;

  always_comb begin
    a_r1_reserved_zero: assert ((ctl_q & ~16'hA800) == 16'h0000);
  end

  a_r2_off_no_new_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |=> ((flags_q & ~$past(flags_q)) == '0));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rd && !edge_q) |=> (flags_q == '0));

  a_r8_idle_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (sidl_q && idle_in) |=> ((flags_q & ~$past(flags_q)) == '0));

  a_r4_irq_follows_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_d != '0) |=> irq);
endmodule

// File: tb/pin_change_notifier_tb.sv
module pin_change_notifier_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] pins_in = '0;
  logic idle_in = 1'b0;
  logic ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_q;
  logic ena_we = 1'b0, enb_we = 1'b0, flag_clr_we = 1'b0;
  logic [W-1:0] cfg_wdata = '0;
  logic pin_rd = 1'b0;
  logic [W-1:0] pin_rdata, flags_q;
  logic irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string        tag;
    logic [W-1:0] flags;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  pin_change_notifier #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .idle_in(idle_in),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .ena_we(ena_we), .enb_we(enb_we), .flag_clr_we(flag_clr_we),
    .cfg_wdata(cfg_wdata), .pin_rd(pin_rd), .pin_rdata(pin_rdata),
    .flags_q(flags_q), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " flags"}, 32'(flags_q), 32'(e.flags));
      check({e.tag, " irq"}, 32'(irq), 32'(e.flags != '0));
    end
  end

  task automatic cyc(string tag, logic [W-1:0] exp);
    exp_t e;
    e.tag = tag;
    e.flags = exp;
    q.push_back(e);
    @(negedge clk);
    ctl_we = 1'b0; ena_we = 1'b0; enb_we = 1'b0; flag_clr_we = 1'b0; pin_rd = 1'b0;
  endtask

  task automatic wr_ctl(logic [15:0] v, logic [W-1:0] exp);
    ctl_we = 1'b1; ctl_wdata = v;
    cyc("ctl write", exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ctl", 32'(ctl_q), 32'h0);
    check("R4 reset irq", 32'(irq), 32'h0);
    check("R3 reset flags", 32'(flags_q), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    wr_ctl(16'hFFFF, 16'h0);
    check("R1 readback", 32'(ctl_q), 32'hA800);
    wr_ctl(16'h0000, 16'h0);

    ena_we = 1'b1; cfg_wdata = 16'h000F;
    cyc("enable A", 16'h0);
    pins_in = 16'h0001;
    cyc("R2 off", 16'h0);
    cyc("R2 off", 16'h0);
    pins_in = 16'h0000;
    cyc("R2 off", 16'h0);
    cyc("R2 off", 16'h0);

    wr_ctl(16'h8000, 16'h0);
    pins_in = 16'h0002;
    cyc("R3 latency", 16'h0);
    cyc("R3 set", 16'h0002);
    pins_in = 16'h0000;
    cyc("R3 sticky", 16'h0002);
    cyc("R4 sticky", 16'h0002);
    pins_in = 16'h0100;
    cyc("R3 unenabled", 16'h0002);
    cyc("R3 unenabled", 16'h0002);
    pins_in = 16'h0002;
    cyc("R3", 16'h0002);
    cyc("R3", 16'h0002);
    check("R5 read data", 32'(pin_rdata), 32'h0002);
    pin_rd = 1'b1;
    cyc("R5 read clears", 16'h0);
    cyc("R5 new reference", 16'h0);
    cyc("R5 new reference", 16'h0);
    pins_in = 16'h0000;
    cyc("R5 mismatch vs new ref", 16'h0);
    cyc("R5 mismatch vs new ref", 16'h0002);
    pins_in = 16'h0002;
    cyc("R5", 16'h0002);
    pin_rd = 1'b1;
    cyc("R5 clear", 16'h0);

    ena_we = 1'b1; cfg_wdata = 16'h0001;
    cyc("rise enable", 16'h0);
    enb_we = 1'b1; cfg_wdata = 16'h0002;
    cyc("fall enable", 16'h0);
    wr_ctl(16'h8800, 16'h0);
    pins_in = 16'h0003;
    cyc("R6 rise", 16'h0);
    cyc("R6 rise", 16'h0001);
    pins_in = 16'h0001;
    cyc("R6 fall", 16'h0001);
    cyc("R6 fall", 16'h0003);
    pins_in = 16'h0000;
    cyc("R6 unarmed fall", 16'h0003);
    cyc("R6 unarmed fall", 16'h0003);
    flag_clr_we = 1'b1; cfg_wdata = 16'h0001;
    cyc("R7 w1c partial", 16'h0002);
    flag_clr_we = 1'b1; cfg_wdata = 16'h0002;
    cyc("R7 w1c all", 16'h0);
    pins_in = 16'h0002;
    cyc("R6 unarmed rise", 16'h0);
    cyc("R6 unarmed rise", 16'h0);

    wr_ctl(16'hA800, 16'h0);
    idle_in = 1'b1;
    pins_in = 16'h0003;
    cyc("R8 idle", 16'h0);
    cyc("R8 idle", 16'h0);
    idle_in = 1'b0;
    cyc("R10 after idle", 16'h0);
    cyc("R10 after idle", 16'h0);
    pins_in = 16'h0002;
    cyc("R8 not idle", 16'h0);
    pins_in = 16'h0003;
    cyc("R9 pulse", 16'h0);
    pins_in = 16'h0002;
    cyc("R9 pulse", 16'h0001);
    cyc("R9 pulse held", 16'h0001);
    flag_clr_we = 1'b1; cfg_wdata = 16'hFFFF;
    cyc("R7 clear", 16'h0);

    wr_ctl(16'h0800, 16'h0);
    pins_in = 16'h0003;
    cyc("R2 off edge", 16'h0);
    cyc("R2 off edge", 16'h0);
    wr_ctl(16'h8800, 16'h0);
    cyc("R10 re-enable", 16'h0);
    cyc("R10 re-enable", 16'h0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule